// File: doc/BRIEF.md
# Leveled Priority Interrupt Arbiter

This block sits between a processor core and two banks of interrupt sources. Each source has a 3-bit level and a 3-bit priority, set by a configuration write. Level 0 turns a source off. A rising request line latches a per-source pending bit. Software clears pending bits with a write-one-to-clear strobe. Every cycle the block finds the strongest pending source across both banks and checks it against the interrupt mask held in the status word.

When the block accepts a request, it does the following in one clock edge:
- It produces a 32-bit exception frame word that holds the vector and the status value from before acceptance.
- It pushes that previous status onto an internal nesting stack.
- It raises the mask to the accepted level.

After an acceptance, further acceptances are held off until the core reports that one instruction has retired. This gives the handler time to raise its own mask. A return-from-exception strobe pops the stack and restores the saved status. A status write port lets software change the mask directly.

Top module: `lpa_arbiter_top`

## Requirements
- R1: After a synchronous reset, the outputs are as follows:
  - status is 0x2700 (supervisor bit 13 set, mask bits 10:8 = 7);
  - pending and nest depth are zero;
  - ack and overflow are low.
- R2: A 0-to-1 change on `irq_req[g]` sets `pending[g]` on the next edge. A 1 in `clr_bits[g]` clears it. If a rising request and a clear arrive in the same cycle, the bit ends up set.
- R3: A source takes part in arbitration only if it is pending and its level is non-zero. Among those, the source with the larger value of {level,priority} wins. Within a bank, a tie goes to the lower index.
- R4: If a bank 0 source and a bank 1 source have the same level and priority, the bank 0 source is taken first.
- R5: Sources at levels 1 to 6 are accepted only when their level is strictly greater than status bits 10:8. Level 7 is accepted at any mask, and its pending bit clears automatically when it is accepted.
- R6: The frame word is {4'h4, 2'b00, vector[7:0], 2'b00, previous_status[15:0]}. The vector is 64 + index for bank 0 and 128 + index for bank 1, where the index is 0 to 15 within the bank. It is presented with `ack` in the cycle after the accepting edge and held until the next acceptance.
- R7: On acceptance, status bits 10:8 become the accepted level. All other status bits keep their values.
- R8: After an acceptance, no further acceptance happens until an `instr_done` pulse has been seen.
- R9: `rte` pops the nesting stack, restores the saved status and lowers the depth by one. An `rte` at depth 0 leaves status and depth unchanged.
- R10: When the depth equals the stack size (8) and a request would otherwise be accepted, the request is not accepted and stays pending. The sticky `overflow` output is set.
- R11: A cycle with `rte` or `sr_we` accepts nothing. When both are asserted together, `rte` wins and the status write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 32 | Request lines, bank 0 in bits 15:0, bank 1 in bits 31:16 |
| cfg_we | input | 1 | Write level and priority for one source |
| cfg_src | input | 5 | Global source index for the configuration write |
| cfg_level | input | 3 | Level to write (0 = disabled) |
| cfg_prio | input | 3 | Priority to write |
| clr_bits | input | 32 | Write-one-to-clear strobe for pending bits |
| sr_we | input | 1 | Status write strobe |
| sr_wdata | input | 16 | Status write value |
| instr_done | input | 1 | Core retired one instruction |
| rte | input | 1 | Return-from-exception strobe |
| ack | output | 1 | One-cycle acceptance pulse |
| ack_level | output | 3 | Level of the accepted source |
| ack_prio | output | 3 | Priority of the accepted source |
| ack_vector | output | 8 | Vector of the accepted source |
| frame_word | output | 32 | Exception frame word of the last acceptance |
| status | output | 16 | Current status word |
| nest_depth | output | 4 | Number of saved status words |
| overflow | output | 1 | Sticky nesting overflow flag |
| pending | output | 32 | Pending bits |

## Verification
The assertions assume that every control input is a known value from the first clock after reset. They also assume that `cfg_src` names an existing source. With 32 sources on a 5-bit index, every value is valid, and the bench drives all inputs to defined values from time zero.

The assertions do not rely on level and priority pairs being unique within a bank. The random phase of the stimulus deliberately writes duplicate pairs, which exercises the lower-index tie rule. The directed phases keep pairs unique, except for the deliberate cross-bank tie.

// File: rtl/lpa_pkg.sv
package lpa_pkg;

    localparam int LVL_W   = 3;
    localparam int PRI_W   = 3;
    localparam int SR_W    = 16;
    localparam int VEC_W   = 8;
    localparam int GIDX_W  = 8;
    localparam int MASK_LO = 8;

    localparam logic [LVL_W-1:0] NMI_LEVEL    = 3'd7;
    localparam logic [3:0]       FRAME_FORMAT = 4'h4;
    localparam logic [SR_W-1:0]  SR_RESET     = 16'h2700;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [PRI_W-1:0] pri_t;
    typedef logic [SR_W-1:0]  sr_t;

    typedef struct packed {
        logic              valid;
        lvl_t              lvl;
        pri_t              pri;
        logic [VEC_W-1:0]  vec;
        logic [GIDX_W-1:0] gidx;
    } cand_t;

    function automatic logic [LVL_W+PRI_W-1:0] cand_key(input cand_t c);
        return {c.lvl, c.pri};
    endfunction

    // a strictly outranks b; an equal key keeps b (earlier entry wins)
    function automatic logic outranks(input cand_t a, input cand_t b);
        return a.valid && (!b.valid || (cand_key(a) > cand_key(b)));
    endfunction

    function automatic lvl_t sr_mask(input sr_t sr);
        return sr[MASK_LO +: LVL_W];
    endfunction

    function automatic sr_t sr_with_mask(input sr_t sr, input lvl_t lvl);
        sr_t r;
        r = sr;
        r[MASK_LO +: LVL_W] = lvl;
        return r;
    endfunction

    function automatic logic level_passes(input lvl_t lvl, input lvl_t mask);
        return (lvl == NMI_LEVEL) || (lvl > mask);
    endfunction

    function automatic logic [31:0] make_frame(input logic [VEC_W-1:0] vec, input sr_t prev);
        return {FRAME_FORMAT, 2'b00, vec, 2'b00, prev};
    endfunction

endpackage

// File: rtl/lpa_pick.sv
module lpa_pick
    import lpa_pkg::*;
#(
    parameter int N = 16
) (
    input  cand_t cand_i [N],
    output cand_t best_o
);

    // Ascending scan with a strict compare: lower entries win ties.
    always_comb begin
        best_o = '0;
        for (int i = 0; i < N; i++) begin
            if (outranks(cand_i[i], best_o)) begin
                best_o = cand_i[i];
            end
        end
    end

endmodule

// File: rtl/lpa_src_bank.sv
module lpa_src_bank
    import lpa_pkg::*;
#(
    parameter int NS         = 16,
    parameter int BANK_ID    = 0,
    parameter int VEC_BASE   = 64,
    parameter int VEC_STRIDE = 64,
    localparam int SIDX_W    = $clog2(NS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NS-1:0]     irq,
    input  logic              cfg_we,
    input  logic [SIDX_W-1:0] cfg_idx,
    input  lvl_t              cfg_lvl,
    input  pri_t              cfg_pri,
    input  logic [NS-1:0]     clr,
    input  logic [NS-1:0]     nmi_clr,
    output logic [NS-1:0]     pend_o,
    output cand_t             best_o
);

    lvl_t          lvl_q [NS];
    pri_t          pri_q [NS];
    logic [NS-1:0] pend_q;
    logic [NS-1:0] irq_q;
    logic [NS-1:0] rise;
    cand_t         cands [NS];

    assign rise   = irq & ~irq_q;
    assign pend_o = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= '0;
            pend_q <= '0;
            for (int i = 0; i < NS; i++) begin
                lvl_q[i] <= '0;
                pri_q[i] <= '0;
            end
        end else begin
            irq_q  <= irq;
            pend_q <= (pend_q & ~clr & ~nmi_clr) | rise;
            if (cfg_we) begin
                lvl_q[cfg_idx] <= cfg_lvl;
                pri_q[cfg_idx] <= cfg_pri;
            end
        end
    end

    for (genvar i = 0; i < NS; i++) begin : g_cand
        assign cands[i] = '{valid: pend_q[i] && (lvl_q[i] != '0),
                            lvl:   lvl_q[i],
                            pri:   pri_q[i],
                            vec:   VEC_W'(VEC_BASE + BANK_ID * VEC_STRIDE + i),
                            gidx:  GIDX_W'(BANK_ID * NS + i)};
    end

    lpa_pick #(.N(NS)) u_pick (
        .cand_i (cands),
        .best_o (best_o)
    );

    // R2: a fresh request edge is never lost, even against a clear
    a_r2_rise_latched: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

endmodule

// File: rtl/lpa_status_stack.sv
module lpa_status_stack
    import lpa_pkg::*;
#(
    parameter int DEPTH    = 8,
    localparam int AW      = $clog2(DEPTH),
    localparam int DEPTH_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  lvl_t               acc_lvl,
    input  logic               rte,
    input  logic               sr_we,
    input  sr_t                sr_wdata,
    output sr_t                status_o,
    output logic [DEPTH_W-1:0] depth_o,
    output logic               full_o
);

    sr_t                stk [DEPTH];
    sr_t                status_q;
    logic [DEPTH_W-1:0] depth_q;

    assign status_o = status_q;
    assign depth_o  = depth_q;
    assign full_o   = (depth_q == DEPTH_W'(DEPTH));

    // Priority: acceptance, then return, then a plain status write.
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= SR_RESET;
            depth_q  <= '0;
        end else if (accept) begin
            stk[AW'(depth_q)] <= status_q;
            status_q          <= sr_with_mask(status_q, acc_lvl);
            depth_q           <= depth_q + 1'b1;
        end else if (rte) begin
            if (depth_q != '0) begin
                status_q <= stk[AW'(depth_q - 1'b1)];
                depth_q  <= depth_q - 1'b1;
            end
        end else if (sr_we) begin
            status_q <= sr_wdata;
        end
    end

    a_r10_depth_bound: assert property (@(posedge clk) disable iff (rst)
        depth_q <= DEPTH_W'(DEPTH));

    a_r10_no_push_full: assert property (@(posedge clk) disable iff (rst)
        accept |-> !full_o);

    a_r9_rte_empty_noop: assert property (@(posedge clk) disable iff (rst)
        (rte && !accept && depth_q == '0) |=> ($stable(status_q) && depth_q == '0));

    a_r9_rte_pops: assert property (@(posedge clk) disable iff (rst)
        (rte && !accept && depth_q != '0) |=> (depth_q == $past(depth_q) - 1'b1));

endmodule

// File: rtl/lpa_arbiter_top.sv
module lpa_arbiter_top
    import lpa_pkg::*;
#(
    parameter int NUM_BANKS    = 2,
    parameter int SRC_PER_BANK = 16,
    parameter int NEST_DEPTH   = 8,
    parameter int VEC_BASE     = 64,
    parameter int VEC_STRIDE   = 64,
    localparam int NSRC        = NUM_BANKS * SRC_PER_BANK,
    localparam int SRC_W       = $clog2(NSRC),
    localparam int SIDX_W      = $clog2(SRC_PER_BANK),
    localparam int DEPTH_W     = $clog2(NEST_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NSRC-1:0]    irq_req,
    input  logic               cfg_we,
    input  logic [SRC_W-1:0]   cfg_src,
    input  logic [2:0]         cfg_level,
    input  logic [2:0]         cfg_prio,
    input  logic [NSRC-1:0]    clr_bits,
    input  logic               sr_we,
    input  logic [15:0]        sr_wdata,
    input  logic               instr_done,
    input  logic               rte,
    output logic               ack,
    output logic [2:0]         ack_level,
    output logic [2:0]         ack_prio,
    output logic [7:0]         ack_vector,
    output logic [31:0]        frame_word,
    output logic [15:0]        status,
    output logic [DEPTH_W-1:0] nest_depth,
    output logic               overflow,
    output logic [NSRC-1:0]    pending
);

    cand_t           bank_best [NUM_BANKS];
    cand_t           winner;
    logic [NSRC-1:0] nmi_clr;
    sr_t             status_w;
    logic            full_w;
    logic            can_take;
    logic            accept;
    logic            inhibit_q;
    logic            ack_q;
    lvl_t            ack_lvl_q;
    pri_t            ack_pri_q;
    logic [7:0]      ack_vec_q;
    logic [31:0]     frame_q;
    logic            ovf_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_we;
        assign bank_we = cfg_we && ((32'(cfg_src) / SRC_PER_BANK) == b);

        lpa_src_bank #(
            .NS         (SRC_PER_BANK),
            .BANK_ID    (b),
            .VEC_BASE   (VEC_BASE),
            .VEC_STRIDE (VEC_STRIDE)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .irq     (irq_req[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .cfg_we  (bank_we),
            .cfg_idx (SIDX_W'(32'(cfg_src) % SRC_PER_BANK)),
            .cfg_lvl (cfg_level),
            .cfg_pri (cfg_prio),
            .clr     (clr_bits[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .nmi_clr (nmi_clr[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .pend_o  (pending[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .best_o  (bank_best[b])
        );
    end

    // Cascade across banks; the strict compare keeps bank 0 on a tie.
    lpa_pick #(.N(NUM_BANKS)) u_bank_pick (
        .cand_i (bank_best),
        .best_o (winner)
    );

    assign can_take = winner.valid && level_passes(winner.lvl, sr_mask(status_w))
                      && !inhibit_q && !rte && !sr_we;
    assign accept   = can_take && !full_w;

    // Edge-style clear for the non-maskable level on acceptance.
    always_comb begin
        nmi_clr = '0;
        if (accept && (winner.lvl == NMI_LEVEL)) begin
            for (int g = 0; g < NSRC; g++) begin
                if (GIDX_W'(g) == winner.gidx) begin
                    nmi_clr[g] = 1'b1;
                end
            end
        end
    end

    lpa_status_stack #(.DEPTH(NEST_DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .acc_lvl  (winner.lvl),
        .rte      (rte),
        .sr_we    (sr_we),
        .sr_wdata (sr_wdata),
        .status_o (status_w),
        .depth_o  (nest_depth),
        .full_o   (full_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q     <= 1'b0;
            ack_lvl_q <= '0;
            ack_pri_q <= '0;
            ack_vec_q <= '0;
            frame_q   <= '0;
            inhibit_q <= 1'b0;
            ovf_q     <= 1'b0;
        end else begin
            ack_q <= accept;
            if (accept) begin
                ack_lvl_q <= winner.lvl;
                ack_pri_q <= winner.pri;
                ack_vec_q <= winner.vec;
                frame_q   <= make_frame(winner.vec, status_w);
                inhibit_q <= 1'b1;
            end else if (instr_done) begin
                inhibit_q <= 1'b0;
            end
            if (can_take && full_w) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign ack        = ack_q;
    assign ack_level  = ack_lvl_q;
    assign ack_prio   = ack_pri_q;
    assign ack_vector = ack_vec_q;
    assign frame_word = frame_q;
    assign status     = status_w;
    assign overflow   = ovf_q;

    a_r7_mask_raised: assert property (@(posedge clk) disable iff (rst)
        ack |-> (status[MASK_LO +: 3] == ack_level));

    a_r5_above_prev_mask: assert property (@(posedge clk) disable iff (rst)
        (ack && ack_level != NMI_LEVEL) |-> (ack_level > frame_word[MASK_LO +: 3]));

    a_r6_prev_status_saved: assert property (@(posedge clk) disable iff (rst)
        ack |-> (frame_word[15:0] == $past(status) && frame_word[31:26] == 6'b010000));

    a_r8_single_accept: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    a_r11_strobe_blocks: assert property (@(posedge clk) disable iff (rst)
        (rte || sr_we) |=> !ack);

endmodule

// File: tb/tb_lpa_arbiter_top.sv
module tb_lpa_arbiter_top;

    localparam int NSRC  = 32;
    localparam int DEPTH = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] irq_req = '0;
    logic            cfg_we = 1'b0;
    logic [4:0]      cfg_src = '0;
    logic [2:0]      cfg_level = '0;
    logic [2:0]      cfg_prio = '0;
    logic [NSRC-1:0] clr_bits = '0;
    logic            sr_we = 1'b0;
    logic [15:0]     sr_wdata = '0;
    logic            instr_done = 1'b0;
    logic            rte = 1'b0;

    logic            ack;
    logic [2:0]      ack_level, ack_prio;
    logic [7:0]      ack_vector;
    logic [31:0]     frame_word;
    logic [15:0]     status;
    logic [3:0]      nest_depth;
    logic            overflow;
    logic [NSRC-1:0] pending;

    always #5 clk = ~clk;

    lpa_arbiter_top dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .cfg_we(cfg_we), .cfg_src(cfg_src),
        .cfg_level(cfg_level), .cfg_prio(cfg_prio), .clr_bits(clr_bits), .sr_we(sr_we),
        .sr_wdata(sr_wdata), .instr_done(instr_done), .rte(rte), .ack(ack),
        .ack_level(ack_level), .ack_prio(ack_prio), .ack_vector(ack_vector),
        .frame_word(frame_word), .status(status), .nest_depth(nest_depth),
        .overflow(overflow), .pending(pending)
    );

    // ---------------- behavioural reference ----------------
    int          m_lvl [NSRC];
    int          m_pri [NSRC];
    bit          m_pend [NSRC];
    bit          m_prev [NSRC];
    logic [15:0] m_stack [$];
    logic [15:0] m_status;
    logic [31:0] m_frame;
    bit          m_inh, m_ovf, m_ack;
    int          m_alvl, m_apri, m_avec;
    int          best, bkey, mask, vec;
    bit          can, acc, rise, clrb;
    logic [NSRC-1:0] m_pvec;

    int    checks = 0;
    int    fails  = 0;
    string phase  = "R1 reset";

    task automatic chk(input string fld, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL [%s] %s got %h exp %h", phase, fld, got, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < NSRC; g++) begin
                m_lvl[g] = 0; m_pri[g] = 0; m_pend[g] = 0; m_prev[g] = 0;
            end
            m_stack.delete();
            m_status = 16'h2700; m_frame = '0;
            m_inh = 0; m_ovf = 0; m_ack = 0;
            m_alvl = 0; m_apri = 0; m_avec = 0;
        end else begin
            best = -1; bkey = -1;
            for (int g = 0; g < NSRC; g++) begin
                if (m_pend[g] && m_lvl[g] != 0 && (m_lvl[g] * 8 + m_pri[g]) > bkey) begin
                    best = g; bkey = m_lvl[g] * 8 + m_pri[g];
                end
            end
            mask = int'(m_status[10:8]);
            can  = (best >= 0) && !m_inh && !rte && !sr_we &&
                   (best >= 0 ? (m_lvl[best] == 7 || m_lvl[best] > mask) : 1'b0);
            acc  = can && (m_stack.size() < DEPTH);
            if (can && m_stack.size() == DEPTH) m_ovf = 1;
            m_ack = acc;
            for (int g = 0; g < NSRC; g++) begin
                rise = irq_req[g] && !m_prev[g];
                clrb = clr_bits[g] || (acc && g == best && m_lvl[best] == 7);
                m_pend[g] = (m_pend[g] && !clrb) || rise;
                m_prev[g] = irq_req[g];
            end
            if (acc) begin
                vec = 64 + (best / 16) * 64 + (best % 16);
                m_frame = {4'h4, 2'b00, 8'(vec), 2'b00, m_status};
                m_stack.push_back(m_status);
                m_status = {m_status[15:11], 3'(m_lvl[best]), m_status[7:0]};
                m_alvl = m_lvl[best]; m_apri = m_pri[best]; m_avec = vec;
                m_inh = 1;
            end else begin
                if (rte) begin
                    if (m_stack.size() > 0) m_status = m_stack.pop_back();
                end else if (sr_we) begin
                    m_status = sr_wdata;
                end
                if (instr_done) m_inh = 0;
            end
            if (cfg_we) begin
                m_lvl[cfg_src] = int'(cfg_level);
                m_pri[cfg_src] = int'(cfg_prio);
            end
        end
        #2;
        for (int g = 0; g < NSRC; g++) m_pvec[g] = m_pend[g];
        chk("status(R7 R9)",   32'(status), 32'(m_status));
        chk("pending(R2)",     pending, m_pvec);
        chk("ack(R5 R8 R11)",  32'(ack), 32'(m_ack));
        chk("level(R3)",       32'(ack_level), 32'(m_alvl));
        chk("prio(R4)",        32'(ack_prio), 32'(m_apri));
        chk("vector(R6)",      32'(ack_vector), 32'(m_avec));
        chk("frame(R6)",       frame_word, m_frame);
        chk("depth(R9)",       32'(nest_depth), 32'(m_stack.size()));
        chk("overflow(R10)",   32'(overflow), 32'(m_ovf));
    end

    // ---------------- stimulus ----------------
    task automatic cyc();
        @(negedge clk);
    endtask
    task automatic idle(input int n);
        repeat (n) cyc();
    endtask
    task automatic cfg(input int src, input int l, input int p);
        cfg_we = 1; cfg_src = 5'(src); cfg_level = 3'(l); cfg_prio = 3'(p);
        cyc();
        cfg_we = 0;
    endtask
    task automatic set_sr(input logic [15:0] v);
        sr_we = 1; sr_wdata = v;
        cyc();
        sr_we = 0;
    endtask
    task automatic done();
        instr_done = 1; cyc(); instr_done = 0;
    endtask
    task automatic ret();
        rte = 1; cyc(); rte = 0;
    endtask
    task automatic clr(input int g);
        clr_bits[g] = 1'b1; cyc(); clr_bits = '0;
    endtask
    task automatic pulse(input int g);
        irq_req[g] = 1'b1; cyc(); irq_req[g] = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL [%s] watchdog R1 got hung exp finished", phase);
        summary();
        $finish;
    end

    initial begin
        idle(3);
        rst = 0;
        phase = "R1 reset idle";
        idle(3);

        phase = "R2 pending set and clear";
        irq_req[3] = 1; cyc(); idle(2);
        irq_req[3] = 0; cyc();
        irq_req[3] = 1; clr_bits[3] = 1; cyc(); clr_bits = '0; idle(1);
        clr(3); idle(1);
        irq_req[3] = 0; cyc();

        phase = "R3 level then priority";
        set_sr(16'h2000);
        cfg(2, 3, 5); cfg(5, 4, 1); cfg(9, 4, 6);
        irq_req[2] = 1; irq_req[5] = 1; irq_req[9] = 1; cyc();
        irq_req = '0; idle(2);
        done(); idle(2);
        clr(9); ret(); idle(2);
        done(); clr(5); ret(); idle(2);
        done(); clr(2); ret(); idle(2);

        phase = "R5 mask gate and level 7";
        set_sr(16'h2300); cfg(6, 3, 0); pulse(6); idle(3);
        set_sr(16'h2200); idle(2); done(); clr(6); ret(); idle(1);
        set_sr(16'h2700); cfg(7, 7, 0); pulse(7); idle(2); done(); ret(); idle(2);

        phase = "R4 bank tie";
        set_sr(16'h2000); cfg(1, 5, 2); cfg(17, 5, 2);
        irq_req[1] = 1; irq_req[17] = 1; cyc(); irq_req = '0; idle(2);
        done(); clr(1); ret(); idle(2);
        done(); clr(17); ret(); idle(2);

        phase = "R8 inhibit window";
        cfg(10, 2, 0); cfg(11, 6, 0); set_sr(16'h2000);
        pulse(10); pulse(11); idle(3);
        done(); idle(2); done();
        clr(10); clr(11); ret(); ret(); idle(2);

        phase = "R11 strobe precedence";
        cfg(12, 5, 0); set_sr(16'h2000);
        rte = 1; sr_we = 1; sr_wdata = 16'h2600; irq_req[12] = 1; cyc(); cyc();
        rte = 0; sr_we = 0; irq_req = '0; idle(2);
        done(); clr(12); ret(); idle(2);

        phase = "R10 nesting overflow";
        set_sr(16'h2000); cfg(20, 7, 3);
        repeat (9) begin pulse(20); idle(2); done(); end
        idle(2);

        phase = "R9 unwind past empty";
        repeat (12) begin ret(); done(); end
        clr(20); idle(2);

        phase = "R3 random mix";
        for (int k = 0; k < 3000; k++) begin
            irq_req    = $urandom & $urandom & $urandom;
            clr_bits   = ($urandom % 8 == 0) ? ($urandom & $urandom) : '0;
            cfg_we     = ($urandom % 10 == 0);
            cfg_src    = 5'($urandom);
            cfg_level  = 3'($urandom);
            cfg_prio   = 3'($urandom);
            sr_we      = ($urandom % 30 == 0);
            sr_wdata   = {2'b00, 1'b1, 2'b00, 3'($urandom), 8'h00};
            rte        = ($urandom % 12 == 0);
            instr_done = ($urandom % 3 == 0);
            cyc();
        end
        irq_req = '0; clr_bits = '0; cfg_we = 0; sr_we = 0; rte = 0; instr_done = 0;
        idle(3);

        summary();
        $finish;
    end

endmodule